// File: doc/BRIEF.md
# Paged Data Address Translator

This block widens a 16-bit data address into a 24-bit physical address through four programmable page pointers. The two most significant bits of the logical address pick one pointer. That pointer's 10-bit page number takes the place of those two bits, above the 14 low offset bits. The 64 KB logical space therefore becomes four independent 16 KB windows, each of which can be placed on any 16 KB page of a 16 MB space.

A simple write port loads a pointer. A combinational read port returns any pointer, zero-extended. A translation request is presented with a valid strobe, and the result appears registered one clock later with its own valid flag. After reset the pointers hold 0, 1, 2 and 3, so the first 64 KB maps onto itself.

Top module: `page_addr_xlat`

## Requirements
- R1: After reset `out_valid` is 0, and the pointers read back as 0, 1, 2 and 3 for selectors 0, 1, 2 and 3.
- R2: When `req_valid` is 1 at a clock edge, `out_addr` after that edge equals `{pointer[req_addr[15:14]], req_addr[13:0]}`. Bits 23:14 are the selected 10-bit page and bits 13:0 are the offset.
- R3: `out_valid` after a clock edge equals the value `req_valid` had at that edge, which gives one cycle of latency.
- R4: A pointer write (`wr_en`=1) updates the pointer at the clock edge. A translation sampled at that same edge still uses the old value. Translations sampled at later edges use the new value.
- R5: Only `wr_data[9:0]` is stored. The bits above bit 9 are ignored, and `rd_data[15:10]` always reads 0.
- R6: Logical address 0xA20A maps to 0x00E20A when pointer 2 holds 3, and to 0x01620A when pointer 2 holds 5.
- R7: When `req_valid` is 0 at a clock edge, `out_addr` keeps its previous value.
- R8: A write to one pointer leaves the other three unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Pointer write strobe |
| wr_sel | input | 2 | Pointer written |
| wr_data | input | 16 | Write data; only bits 9:0 are kept |
| rd_sel | input | 2 | Pointer read back |
| rd_data | output | 16 | Selected pointer, zero-extended |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 16 | Logical address |
| out_valid | output | 1 | Registered request strobe |
| out_addr | output | 24 | Registered physical address |

## Verification
Every selector is swept against page values that include all-zero, all-one, alternating bit patterns and pseudo-random values. Each of these is crossed with offsets at both window edges and in the middle, so a swapped selector, a misplaced page field or a truncated offset shows up as a wrong bit field. A write and a request in the same cycle separate a pointer that updates too early from one that updates on time. A write with its upper bits set exposes data that leaks past bit 9. Idle cycles show whether the output holds its value or follows the input.

// File: rtl/page_xlat_pkg.sv
`timescale 1ns/1ps
package page_xlat_pkg;
    localparam int unsigned LOG_W_DEF  = 16;  // logical address width
    localparam int unsigned SEL_W_DEF  = 2;   // pointer selector width
    localparam int unsigned PAGE_W_DEF = 10;  // page number width
    localparam int unsigned DATA_W_DEF = 16;  // register port width
endpackage

// File: rtl/page_ptr_bank.sv
`timescale 1ns/1ps
module page_ptr_bank #(
    parameter int unsigned SEL_W  = 2,
    parameter int unsigned PAGE_W = 10,
    localparam int unsigned NUM_PTR = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [PAGE_W-1:0] wr_page,
    output logic [PAGE_W-1:0] ptr [NUM_PTR]
);
    logic [PAGE_W-1:0] ptr_d [NUM_PTR];
    logic [PAGE_W-1:0] ptr_q [NUM_PTR];

    always_comb begin
        for (int i = 0; i < NUM_PTR; i++) begin
            ptr_d[i] = ptr_q[i];
        end
        if (wr_en) begin
            ptr_d[wr_sel] = wr_page;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PTR; i++) begin
                ptr_q[i] <= PAGE_W'(i);
            end
        end else begin
            for (int i = 0; i < NUM_PTR; i++) begin
                ptr_q[i] <= ptr_d[i];
            end
        end
    end

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_out
        assign ptr[g] = ptr_q[g];
    end
endmodule

// File: rtl/page_addr_map.sv
`timescale 1ns/1ps
module page_addr_map #(
    parameter int unsigned LOG_W  = 16,
    parameter int unsigned SEL_W  = 2,
    parameter int unsigned PAGE_W = 10,
    localparam int unsigned NUM_PTR = 1 << SEL_W,
    localparam int unsigned OFF_W   = LOG_W - SEL_W,
    localparam int unsigned PHYS_W  = PAGE_W + OFF_W
) (
    input  logic [LOG_W-1:0]  log_addr,
    input  logic [PAGE_W-1:0] ptr [NUM_PTR],
    output logic [PHYS_W-1:0] phys_addr
);
    logic [SEL_W-1:0] sel;

    always_comb begin
        sel       = log_addr[LOG_W-1 -: SEL_W];
        phys_addr = {ptr[sel], log_addr[OFF_W-1:0]};
    end
endmodule

// File: rtl/page_addr_xlat.sv
`timescale 1ns/1ps
module page_addr_xlat
    import page_xlat_pkg::*;
#(
    parameter int unsigned LOG_W  = LOG_W_DEF,
    parameter int unsigned SEL_W  = SEL_W_DEF,
    parameter int unsigned PAGE_W = PAGE_W_DEF,
    parameter int unsigned DATA_W = DATA_W_DEF,
    localparam int unsigned NUM_PTR = 1 << SEL_W,
    localparam int unsigned OFF_W   = LOG_W - SEL_W,
    localparam int unsigned PHYS_W  = PAGE_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              req_valid,
    input  logic [LOG_W-1:0]  req_addr,
    output logic              out_valid,
    output logic [PHYS_W-1:0] out_addr
);
    typedef struct packed {
        logic              valid;
        logic [PHYS_W-1:0] addr;
    } xlat_out_t;

    logic [PAGE_W-1:0] ptr [NUM_PTR];
    logic [PHYS_W-1:0] phys;
    xlat_out_t         res_d, res_q;
    logic              unused_wr_hi;

    // bits above the page field are dropped on write
    assign unused_wr_hi = ^wr_data[DATA_W-1:PAGE_W];

    page_ptr_bank #(
        .SEL_W  (SEL_W),
        .PAGE_W (PAGE_W)
    ) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_page (wr_data[PAGE_W-1:0]),
        .ptr     (ptr)
    );

    page_addr_map #(
        .LOG_W  (LOG_W),
        .SEL_W  (SEL_W),
        .PAGE_W (PAGE_W)
    ) i_map (
        .log_addr  (req_addr),
        .ptr       (ptr),
        .phys_addr (phys)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = req_valid;
        if (req_valid) begin
            res_d.addr = phys;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign rd_data   = DATA_W'(ptr[rd_sel]);
    assign out_valid = res_q.valid;
    assign out_addr  = res_q.addr;
endmodule

// File: rtl/page_addr_xlat_chk.sv
`timescale 1ns/1ps
module page_addr_xlat_chk #(
    parameter int unsigned LOG_W  = 16,
    parameter int unsigned SEL_W  = 2,
    parameter int unsigned PAGE_W = 10,
    parameter int unsigned DATA_W = 16,
    localparam int unsigned OFF_W  = LOG_W - SEL_W,
    localparam int unsigned PHYS_W = PAGE_W + OFF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic [SEL_W-1:0]  rd_sel,
    input logic [DATA_W-1:0] rd_data,
    input logic              req_valid,
    input logic [LOG_W-1:0]  req_addr,
    input logic              out_valid,
    input logic [PHYS_W-1:0] out_addr
);
    // R3
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    // R3
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);
    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_addr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0]));
    // R4
    page_old_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rd_sel == req_addr[LOG_W-1 -: SEL_W])
        |=> out_addr[PHYS_W-1:OFF_W] == $past(rd_data[PAGE_W-1:0]));
    // R5
    write_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_sel != $past(wr_sel)) ||
                  (rd_data == DATA_W'($past(wr_data[PAGE_W-1:0]))));
    // R7
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(out_addr));
endmodule

bind page_addr_xlat page_addr_xlat_chk #(
    .LOG_W  (LOG_W),
    .SEL_W  (SEL_W),
    .PAGE_W (PAGE_W),
    .DATA_W (DATA_W)
) i_chk (.*);

// File: tb/test_page_addr_xlat.sv
`timescale 1ns/1ps
module test_page_addr_xlat;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        out_valid;
    logic [23:0] out_addr;

    int compared = 0;
    int mismatched = 0;
    logic [9:0] model [4];
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    page_addr_xlat i_page_addr_xlat (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    function automatic logic [23:0] expect_phys(logic [15:0] a);
        return {model[a[15:14]], a[13:0]};
    endfunction

    task automatic write_ptr(logic [1:0] s, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d; req_valid = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        model[s] = d[9:0];
    endtask

    task automatic xlate(string req, logic [15:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, {31'd0, out_valid}, 32'd1);
        check(req, {8'd0, out_addr}, {8'd0, expect_phys(a)});
    endtask

    initial begin
        logic [15:0] lfsr;
        logic [23:0] held;
        logic [9:0] pages [8];
        logic [13:0] offs [6];
        for (int i = 0; i < 4; i++) model[i] = 10'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", {31'd0, out_valid}, 32'd0);
        for (int i = 0; i < 4; i++) begin
            rd_sel = 2'(i); #0.1;
            check("R1", {16'd0, rd_data}, i);
        end
        // R2 identity map after reset
        xlate("R2", 16'h0000); xlate("R2", 16'h3FFF);
        xlate("R2", 16'h4000); xlate("R2", 16'hFFFF);
        // R6 worked examples
        write_ptr(2'd2, 16'd3);
        xlate("R6", 16'hA20A);
        check("R6", {8'd0, out_addr}, 32'h00E20A);
        write_ptr(2'd2, 16'd5);
        xlate("R6", 16'hA20A);
        check("R6", {8'd0, out_addr}, 32'h01620A);
        // R5 upper write bits ignored
        write_ptr(2'd1, 16'hFC07);
        rd_sel = 2'd1; #0.1;
        check("R5", {16'd0, rd_data}, 32'h0007);
        xlate("R5", 16'h4123);
        // R8 others untouched
        rd_sel = 2'd0; #0.1; check("R8", {16'd0, rd_data}, 32'd0);
        rd_sel = 2'd2; #0.1; check("R8", {16'd0, rd_data}, 32'd5);
        rd_sel = 2'd3; #0.1; check("R8", {16'd0, rd_data}, 32'd3);
        // R4 write and request in the same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd3; wr_data = 16'h02AA;
        req_valid = 1'b1; req_addr = 16'hC001;
        @(negedge clk);
        wr_en = 1'b0;
        check("R4 old", {8'd0, out_addr}, {8'd0, 10'd3, 14'h0001});
        model[3] = 10'h2AA;
        req_addr = 16'hC002;
        @(negedge clk);
        req_valid = 1'b0;
        check("R4 new", {8'd0, out_addr}, {8'd0, 10'h2AA, 14'h0002});
        // R7 / R3 idle hold
        held = out_addr;
        req_addr = 16'h1234;
        @(negedge clk);
        check("R3", {31'd0, out_valid}, 32'd0);
        check("R7", {8'd0, out_addr}, {8'd0, held});
        @(negedge clk);
        check("R7", {8'd0, out_addr}, {8'd0, held});
        // R2 sweep: selectors x pages x offsets
        lfsr = 16'hACE1;
        pages[0] = 10'h000; pages[1] = 10'h3FF; pages[2] = 10'h155;
        pages[3] = 10'h2AA; pages[4] = 10'h001; pages[5] = 10'h200;
        offs[0] = 14'h0000; offs[1] = 14'h3FFF; offs[2] = 14'h1555;
        offs[3] = 14'h2AAA; offs[4] = 14'h2000; offs[5] = 14'h0001;
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 8; p++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                if (p >= 6) pages[p] = lfsr[9:0];
                write_ptr(2'(s), {lfsr[15:10], pages[p]});
                for (int o = 0; o < 6; o++) begin
                    xlate("R2", {2'(s), offs[o]});
                end
            end
        end
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end
endmodule